// File: doc/BRIEF.md
# Logical-Processor-Tagged Translation Buffer with Deferred Flush

This block is a small, fully associative address translation cache serving one physical processor that is time-shared among many virtual-machine processors. Every entry carries the identifier of the logical processor that installed it. Translations from several guests can therefore share the buffer. A lookup presents an identifier and a virtual page number. One cycle later it receives a hit indication and, on a hit, the physical page number. On a miss, a fill installs the missing translation.

A scheduler may place any ready logical processor on this physical processor. When it does, it signals a dispatch. The block does not flush on every dispatch. It keeps one "dirty" bit per logical processor. The bit is raised when that processor executes a purge instruction that is local to it, as opposed to a broadcast purge. On dispatch, the entries of the incoming processor are kept and reused if its bit is low. If the bit is high, all of that processor's entries are dropped in a single clock and the bit is lowered.

Two free-running counters let software form the ratio of translation misses to executed instructions. One counts accepted lookups that miss. The other counts retired instructions.

Top module: `vm_tlb`

## Requirements
- R1: A lookup hits only when a valid entry matches both the logical-processor identifier and the virtual page. The response appears one cycle after acceptance, with `rsp_hit`=1 and `rsp_rpn` taken from that entry. A fill accepted in the same cycle as a lookup is not seen by that lookup.
- R2: `miss_count` rises by one for each accepted lookup that misses and is unchanged otherwise. `instr_count` rises by one in each cycle with `instr_retire` high. Both counters wrap.
- R3: `lp_purge_valid` raises the dirty bit of `lp_purge_id`. Dispatching a processor whose bit is low leaves all of its entries usable.
- R4: Dispatching a processor whose bit is high invalidates every entry tagged with that identifier in that clock and lowers the bit. Entries of other processors are untouched, and a second dispatch of the same processor then leaves newly filled entries in place.
- R5: A lookup accepted in the same cycle as a flushing dispatch of its own identifier reports a miss.
- R6: A fill whose identifier and page match a valid entry overwrites that entry's physical page and does not advance the replacement pointer.
- R7: A fill with no matching entry writes the slot under a round-robin pointer. The pointer starts at slot 0 after reset and steps by one, wrapping after the last slot. With 16 slots, the 17th distinct fill after reset evicts the first.
- R8: `fill_ready` is low in any cycle with `disp_valid` high, and a fill offered then is not installed.
- R9: `lk_ready` is high when no response is held or `rsp_ready` is high. While `rsp_valid` is high and `rsp_ready` low, the response fields stay stable.
- R10: After reset, no entry is valid, all dirty bits are low, both counters are zero and `rsp_valid` is low.
- R11: When a purge instruction and a dispatch name the same processor in one cycle, the bit ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_lp | input | LP_W | Logical-processor identifier of the lookup |
| lk_vpn | input | VPN_W | Virtual page of the lookup |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_rpn | output | RPN_W | Physical page on a hit, zero on a miss |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted when high with fill_valid |
| fill_lp | input | LP_W | Identifier tag of the fill |
| fill_vpn | input | VPN_W | Virtual page of the fill |
| fill_rpn | input | RPN_W | Physical page of the fill |
| lp_purge_valid | input | 1 | Local purge instruction executed |
| lp_purge_id | input | LP_W | Processor that executed it |
| disp_valid | input | 1 | A logical processor is dispatched here |
| disp_id | input | LP_W | Processor being dispatched |
| instr_retire | input | 1 | One instruction retired this cycle |
| miss_count | output | CNT_W | Accepted lookups that missed |
| instr_count | output | CNT_W | Retired instructions |

## Verification
The properties assume that the consumer of the response may stall at will, and that lookup identifiers and dispatch identifiers may collide in any cycle. They also assume that `instr_retire` is a plain per-cycle pulse. No input protocol is required beyond valid/ready, so the random stimulus toggles every valid and `rsp_ready` independently. It draws identifiers from a narrow range of four processors and pages from a range of eight, so that hits, overwrites, same-cycle flushes and dirty bits raised and cleared together occur often. Directed sequences add a full wrap of the replacement pointer and stalled responses.

// File: rtl/vm_tlb_pkg.sv
package vm_tlb_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_LP_W    = 4;
  localparam int unsigned DEF_VPN_W   = 20;
  localparam int unsigned DEF_RPN_W   = 20;
  localparam int unsigned DEF_CNT_W   = 32;
endpackage

// File: rtl/vm_tlb_store.sv
module vm_tlb_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned LP_W    = 4,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned RPN_W   = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LP_W-1:0]  lk_lp,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [RPN_W-1:0] lk_rpn,
  input  logic             purge_en,
  input  logic [LP_W-1:0]  purge_lp,
  input  logic             fill_en,
  input  logic [LP_W-1:0]  fill_lp,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [RPN_W-1:0] fill_rpn
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [LP_W-1:0]    tag_lp  [ENTRIES];
  logic [VPN_W-1:0]   tag_vpn [ENTRIES];
  logic [RPN_W-1:0]   data_rpn[ENTRIES];

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] fill_match;
  logic [ENTRIES-1:0] purge_sel;
  logic [ENTRIES-1:0] wr_sel;
  logic [IDX_W-1:0]   rr_ptr;
  logic               fill_reuse;

  assign fill_reuse = |fill_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign purge_sel[g]  = purge_en && vld[g] && (tag_lp[g] == purge_lp);
    assign lk_match[g]   = vld[g] && !purge_sel[g] &&
                           (tag_lp[g] == lk_lp) && (tag_vpn[g] == lk_vpn);
    assign fill_match[g] = vld[g] && (tag_lp[g] == fill_lp) && (tag_vpn[g] == fill_vpn);
    assign wr_sel[g]     = fill_en &&
                           (fill_reuse ? fill_match[g] : (rr_ptr == IDX_W'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g] <= 1'b0;
      end else if (wr_sel[g]) begin
        vld[g] <= 1'b1;
      end else if (purge_sel[g]) begin
        vld[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_sel[g]) begin
        tag_lp[g]   <= fill_lp;
        tag_vpn[g]  <= fill_vpn;
        data_rpn[g] <= fill_rpn;
      end
    end
  end

  always_comb begin
    lk_rpn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_rpn = lk_rpn | data_rpn[i];
    end
  end
  assign lk_hit = |lk_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (fill_en && !fill_reuse) begin
      rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/vm_tlb_lpflags.sv
module vm_tlb_lpflags #(
  parameter int unsigned LP_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [LP_W-1:0] set_lp,
  input  logic            clr_en,
  input  logic [LP_W-1:0] clr_lp,
  input  logic [LP_W-1:0] query_lp,
  output logic            query_flag
);
  localparam int unsigned NUM_LP = 1 << LP_W;

  logic [NUM_LP-1:0] dirty;

  for (genvar g = 0; g < NUM_LP; g++) begin : g_lp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dirty[g] <= 1'b0;
      end else if (set_en && (set_lp == LP_W'(g))) begin
        dirty[g] <= 1'b1;
      end else if (clr_en && (clr_lp == LP_W'(g))) begin
        dirty[g] <= 1'b0;
      end
    end
  end

  assign query_flag = dirty[query_lp];
endmodule

// File: rtl/vm_tlb_perf.sv
module vm_tlb_perf #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_inc,
  input  logic             instr_inc,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] instr_count
);
  localparam int unsigned NUM_CNT = 2;

  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  assign inc = {instr_inc, miss_inc};

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g] <= '0;
      end else if (inc[g]) begin
        cnt[g] <= cnt[g] + 1'b1;
      end
    end
  end

  assign miss_count  = cnt[0];
  assign instr_count = cnt[1];
endmodule

// File: rtl/vm_tlb.sv
module vm_tlb
  import vm_tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned LP_W    = DEF_LP_W,
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned RPN_W   = DEF_RPN_W,
  parameter int unsigned CNT_W   = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [LP_W-1:0]  lk_lp,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic [RPN_W-1:0] rsp_rpn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [LP_W-1:0]  fill_lp,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [RPN_W-1:0] fill_rpn,
  input  logic             lp_purge_valid,
  input  logic [LP_W-1:0]  lp_purge_id,
  input  logic             disp_valid,
  input  logic [LP_W-1:0]  disp_id,
  input  logic             instr_retire,
  output logic [CNT_W-1:0] miss_count,
  output logic [CNT_W-1:0] instr_count
);
  logic             lk_fire;
  logic             fill_fire;
  logic             disp_dirty;
  logic             flush_now;
  logic             st_hit;
  logic [RPN_W-1:0] st_rpn;

  // A held response that is not being taken blocks new lookups.
  assign lk_ready   = !rsp_valid || rsp_ready;
  assign lk_fire    = lk_valid && lk_ready;
  // Dispatch owns the tag array for its cycle; fills wait.
  assign fill_ready = !disp_valid;
  assign fill_fire  = fill_valid && fill_ready;
  assign flush_now  = disp_valid && disp_dirty;

  vm_tlb_lpflags #(.LP_W(LP_W)) i_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_en     (lp_purge_valid),
    .set_lp     (lp_purge_id),
    .clr_en     (flush_now),
    .clr_lp     (disp_id),
    .query_lp   (disp_id),
    .query_flag (disp_dirty)
  );

  vm_tlb_store #(
    .ENTRIES (ENTRIES),
    .LP_W    (LP_W),
    .VPN_W   (VPN_W),
    .RPN_W   (RPN_W)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_lp    (lk_lp),
    .lk_vpn   (lk_vpn),
    .lk_hit   (st_hit),
    .lk_rpn   (st_rpn),
    .purge_en (flush_now),
    .purge_lp (disp_id),
    .fill_en  (fill_fire),
    .fill_lp  (fill_lp),
    .fill_vpn (fill_vpn),
    .fill_rpn (fill_rpn)
  );

  vm_tlb_perf #(.CNT_W(CNT_W)) i_perf (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_inc    (lk_fire && !st_hit),
    .instr_inc   (instr_retire),
    .miss_count  (miss_count),
    .instr_count (instr_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rpn   <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= st_hit;
      rsp_rpn   <= st_rpn;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vm_tlb_chk.sv
module vm_tlb_chk #(
  parameter int unsigned LP_W  = 4,
  parameter int unsigned RPN_W = 20,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_ready,
  input logic [LP_W-1:0]  lk_lp,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [RPN_W-1:0] rsp_rpn,
  input logic             disp_valid,
  input logic [LP_W-1:0]  disp_id,
  input logic             flush_now,
  input logic             instr_retire,
  input logic [CNT_W-1:0] miss_count,
  input logic [CNT_W-1:0] instr_count
);
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_rpn)));

  a_r2_miss_count: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=>
      (rsp_hit ? (miss_count == $past(miss_count))
               : (miss_count == CNT_W'($past(miss_count) + 1'b1))));

  a_r2_miss_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> $stable(miss_count));

  a_r2_instr_count: assert property (@(posedge clk) disable iff (!rst_n)
    instr_retire |=> (instr_count == CNT_W'($past(instr_count) + 1'b1)));

  a_r5_flush_lookup_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && flush_now && (lk_lp == disp_id)) |=> !rsp_hit);

  a_r4_after_flush_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && $past(flush_now) && (lk_lp == $past(disp_id))) |=> !rsp_hit);

  a_r1_miss_zero_rpn: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_rpn == '0));
endmodule

bind vm_tlb vm_tlb_chk #(
  .LP_W  (LP_W),
  .RPN_W (RPN_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .lk_lp        (lk_lp),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_hit      (rsp_hit),
  .rsp_rpn      (rsp_rpn),
  .disp_valid   (disp_valid),
  .disp_id      (disp_id),
  .flush_now    (flush_now),
  .instr_retire (instr_retire),
  .miss_count   (miss_count),
  .instr_count  (instr_count)
);

// File: tb/test_vm_tlb.sv
module test_vm_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_ready, rsp_valid, rsp_ready, rsp_hit;
  logic [3:0]  lk_lp, fill_lp, lp_purge_id, disp_id;
  logic [19:0] lk_vpn, rsp_rpn, fill_vpn, fill_rpn;
  logic        fill_valid, fill_ready, lp_purge_valid, disp_valid, instr_retire;
  logic [31:0] miss_count, instr_count;

  int checks = 0;
  int fails  = 0;

  // reference state
  bit          mv   [NE];
  logic [3:0]  mlp  [NE];
  logic [19:0] mvpn [NE];
  logic [19:0] mrpn [NE];
  bit          mflag[16];
  int          mptr;
  bit          m_rv, m_rh;
  logic [19:0] m_rr;
  logic [31:0] m_miss, m_instr;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_tlb i_vm_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_lp(lk_lp), .lk_vpn(lk_vpn),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_rpn(rsp_rpn),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_lp(fill_lp),
    .fill_vpn(fill_vpn), .fill_rpn(fill_rpn),
    .lp_purge_valid(lp_purge_valid), .lp_purge_id(lp_purge_id),
    .disp_valid(disp_valid), .disp_id(disp_id),
    .instr_retire(instr_retire),
    .miss_count(miss_count), .instr_count(instr_count)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_lookup(input logic [3:0] lp, input logic [19:0] vpn,
                                    input bit flush, input logic [3:0] flp,
                                    output logic [19:0] rpn);
    rpn = '0;
    if (flush && lp == flp) return 1'b0;
    for (int i = 0; i < NE; i++)
      if (mv[i] && mlp[i] == lp && mvpn[i] == vpn) begin
        rpn = mrpn[i];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  function automatic void ref_fill(input logic [3:0] lp, input logic [19:0] vpn,
                                   input logic [19:0] rpn);
    for (int i = 0; i < NE; i++)
      if (mv[i] && mlp[i] == lp && mvpn[i] == vpn) begin
        mrpn[i] = rpn;
        return;
      end
    mv[mptr] = 1'b1; mlp[mptr] = lp; mvpn[mptr] = vpn; mrpn[mptr] = rpn;
    mptr = (mptr + 1) % NE;
  endfunction

  task automatic idle();
    lk_valid = 0; lk_lp = 0; lk_vpn = 0; rsp_ready = 1;
    fill_valid = 0; fill_lp = 0; fill_vpn = 0; fill_rpn = 0;
    lp_purge_valid = 0; lp_purge_id = 0; disp_valid = 0; disp_id = 0;
    instr_retire = 0;
  endtask

  // Called just after a falling edge with inputs set; checks after the next one.
  task automatic tick(input string tag);
    bit          exp_lkr, fire, flush, hit;
    logic [19:0] rpn;
    #1;
    exp_lkr = !m_rv || rsp_ready;
    chk("R9", "lk_ready", lk_ready, exp_lkr);
    chk("R8", "fill_ready", fill_ready, !disp_valid);
    fire  = lk_valid && exp_lkr;
    flush = disp_valid && mflag[disp_id];
    hit   = ref_lookup(lk_lp, lk_vpn, flush, disp_id, rpn);
    @(posedge clk);
    if (fire) begin
      m_rv = 1; m_rh = hit; m_rr = rpn;
      if (!hit) m_miss++;
    end else if (rsp_ready) m_rv = 0;
    if (instr_retire) m_instr++;
    if (flush) begin
      for (int i = 0; i < NE; i++) if (mlp[i] == disp_id) mv[i] = 0;
      mflag[disp_id] = 0;
    end
    if (lp_purge_valid) mflag[lp_purge_id] = 1;
    if (fill_valid && !disp_valid) ref_fill(fill_lp, fill_vpn, fill_rpn);
    @(negedge clk);
    chk(tag, "rsp_valid", rsp_valid, m_rv);
    if (m_rv) begin
      chk(tag, "rsp_hit", rsp_hit, m_rh);
      chk(tag, "rsp_rpn", rsp_rpn, m_rh ? m_rr : 20'h0);
    end
    chk("R2", "miss_count", miss_count, m_miss);
    chk("R2", "instr_count", instr_count, m_instr);
    idle();
  endtask

  task automatic do_fill(input string tag, input logic [3:0] lp, input logic [19:0] vpn,
                         input logic [19:0] rpn);
    fill_valid = 1; fill_lp = lp; fill_vpn = vpn; fill_rpn = rpn;
    tick(tag);
  endtask

  task automatic do_look(input string tag, input logic [3:0] lp, input logic [19:0] vpn);
    lk_valid = 1; lk_lp = lp; lk_vpn = vpn;
    tick(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    for (int i = 0; i < NE; i++) mv[i] = 0;
    for (int i = 0; i < 16; i++) mflag[i] = 0;
    mptr = 0; m_rv = 0; m_rh = 0; m_rr = 0; m_miss = 0; m_instr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R10", "rsp_valid", rsp_valid, 0);
    chk("R10", "miss_count", miss_count, 0);
    chk("R10", "instr_count", instr_count, 0);
    do_look("R10", 4'd0, 20'd0);   // no entry valid after reset

    // R7: seventeen distinct fills wrap the pointer and evict the first
    for (int i = 0; i < 17; i++) do_fill("R7", 4'd5, 20'd100 + 20'(i), 20'h1000 + 20'(i));
    do_look("R7", 4'd5, 20'd100);
    do_look("R7", 4'd5, 20'd101);
    do_look("R7", 4'd5, 20'd116);

    // R6: overwrite keeps the pointer, then a new fill takes the next slot
    do_fill("R6", 4'd5, 20'd103, 20'hABCDE);
    do_look("R6", 4'd5, 20'd103);
    do_fill("R6", 4'd5, 20'd300, 20'h00300);
    do_look("R6", 4'd5, 20'd101);
    do_look("R6", 4'd5, 20'd102);

    // R1: tag must match, and a same-cycle fill is invisible
    do_fill("R1", 4'd1, 20'd5, 20'h0AAAA);
    do_look("R1", 4'd1, 20'd5);
    do_look("R1", 4'd2, 20'd5);
    lk_valid = 1; lk_lp = 4'd2; lk_vpn = 20'd7;
    fill_valid = 1; fill_lp = 4'd2; fill_vpn = 20'd7; fill_rpn = 20'h07777;
    tick("R1");
    do_look("R1", 4'd2, 20'd7);

    // R3: clean dispatch keeps entries
    disp_valid = 1; disp_id = 4'd1; tick("R3");
    do_look("R3", 4'd1, 20'd5);

    // R5 / R4: dirty dispatch flushes only that processor
    lp_purge_valid = 1; lp_purge_id = 4'd1; tick("R3");
    do_fill("R4", 4'd2, 20'd5, 20'h0BBBB);
    disp_valid = 1; disp_id = 4'd1; lk_valid = 1; lk_lp = 4'd1; lk_vpn = 20'd5;
    tick("R5");
    do_look("R4", 4'd1, 20'd5);
    do_look("R4", 4'd2, 20'd5);
    do_fill("R4", 4'd1, 20'd5, 20'h0CCCC);
    disp_valid = 1; disp_id = 4'd1; tick("R4");
    do_look("R4", 4'd1, 20'd5);

    // R11: set and clear together leave the bit set
    do_fill("R11", 4'd3, 20'd9, 20'h09999);
    lp_purge_valid = 1; lp_purge_id = 4'd3; disp_valid = 1; disp_id = 4'd3;
    tick("R11");
    do_look("R11", 4'd3, 20'd9);
    disp_valid = 1; disp_id = 4'd3; tick("R11");
    do_look("R11", 4'd3, 20'd9);

    // R8: fill during dispatch is refused
    disp_valid = 1; disp_id = 4'd7;
    fill_valid = 1; fill_lp = 4'd7; fill_vpn = 20'd44; fill_rpn = 20'h04444;
    tick("R8");
    do_look("R8", 4'd7, 20'd44);

    // R9: stalled response
    lk_valid = 1; lk_lp = 4'd1; lk_vpn = 20'd5; rsp_ready = 0; tick("R9");
    lk_valid = 1; lk_lp = 4'd2; lk_vpn = 20'd5; rsp_ready = 0; tick("R9");
    lk_valid = 1; lk_lp = 4'd2; lk_vpn = 20'd5; rsp_ready = 1; tick("R9");
    tick("R9");

    // random mix across R1..R11
    for (int n = 0; n < 3000; n++) begin
      lk_valid       = ($urandom % 10) < 7;
      lk_lp          = 4'($urandom % 4);
      lk_vpn         = 20'($urandom % 8);
      rsp_ready      = ($urandom % 10) < 8;
      fill_valid     = ($urandom % 10) < 3;
      fill_lp        = 4'($urandom % 4);
      fill_vpn       = 20'($urandom % 8);
      fill_rpn       = 20'($urandom);
      lp_purge_valid = ($urandom % 20) == 0;
      lp_purge_id    = 4'($urandom % 4);
      disp_valid     = ($urandom % 10) == 0;
      disp_id        = 4'($urandom % 4);
      instr_retire   = $urandom % 2;
      tick("R1");
    end

    summary();
    $finish;
  end
endmodule